// File: doc/BRIEF.md
# Host-Windowed Dual Packet Buffer

This block holds two byte-wide packet memories of equal size, one for outgoing frames and one for incoming frames. The host reaches them through a small register window. A 16-bit pointer addresses the memories. Two data ports read or write the byte at that pointer and then step the pointer. A mode register decides which of the two memories the host sees. The other memory belongs to the network side at that moment. The network side is a plain byte stream: a transmit engine reads the outgoing memory, and a receive engine fills the incoming memory.

The host builds a frame so that it ends on the last byte of the outgoing memory. It reloads the pointer with the first byte of the frame, then writes the start-transmit and ownership bits together. The engine sends bytes up to the end of the memory and then drops its busy flag. For reception, the host sets the pointer and enables receive. The engine stores bytes until the last one arrives and leaves the frame length in a counter that the host can read. A DMA-active flag is also kept in the mode register; an external completion pulse clears it.

Top module: `pktbuf_window`

## Requirements
- R1: After a synchronous active-low reset, the pointer is 0, every mode bit is 0 (outgoing memory on the host side, nothing running), the status register (offset 0x13) reads 0x00 and the received-byte count reads 0.
- R2: A write to offset 0x10 loads pointer bits 7:0 and a write to offset 0x11 loads pointer bits 15:8. A read of 0x10 returns bits 7:0 of the received-byte count and a read of 0x11 returns bits 15:8.
- R3: An accepted access at a data port reaches the byte at pointer modulo the buffer size (2048), so pointer 0x0805 reaches byte 0x005. After the access the 16-bit pointer increases by one.
- R4: Mode bit 0 selects the host-side memory: 1 gives the incoming memory at port 0x14, 0 gives the outgoing memory at port 0x15. An access to the port of the memory not on the host side is ignored: no write, read data 0x00, pointer unchanged.
- R5: Writing mode bit 5 = 1 while idle starts transmit at byte (pointer mod 2048). One byte goes out for each cycle with net_tx_valid and net_tx_ready high, in rising address order, through byte 2047, which carries net_tx_last. Status bit 4 reads 1 from the start until that last byte is accepted, and then it clears.
- R6: A transmit in progress only presents bytes while mode bit 0 is 1. While bit 0 is 0, net_tx_valid stays low and the send position holds. Setting bit 0 again (with bit 5 still 1) resumes from that position.
- R7: Writing mode bit 6 = 1 while idle enables receive at byte (pointer mod 2048) and clears the count. Each net_rx_valid byte is stored at the next address and increments the count. A byte with net_rx_last ends the frame and clears status bit 5. Bytes offered while receive is disabled are dropped and leave the count unchanged.
- R8: While mode bit 0 is 1, the receive engine accepts nothing: bytes are dropped, the count holds and status bit 5 stays 1.
- R9: Writing mode bit 7 = 1 sets status bit 3. A dma_done pulse clears it.
- R10: A mode write with bit 5, 6 or 7 at 0 clears the matching activity at once. Status bits 7:6 and 2:0 always read 0.
- R11: The receive write address wraps from byte 2047 to byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 5 | Host register offset |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for the offset on host_addr |
| net_tx_valid | output | 1 | Transmit byte available |
| net_tx_ready | input | 1 | Network side takes the transmit byte |
| net_tx_data | output | 8 | Transmit byte |
| net_tx_last | output | 1 | Transmit byte is the final buffer byte |
| net_rx_valid | input | 1 | Receive byte offered |
| net_rx_data | input | 8 | Receive byte |
| net_rx_last | input | 1 | Receive byte closes the frame |
| dma_done | input | 1 | Completion pulse for the DMA-active flag |

## Verification
The hardest case to reach from the ports is a transmit that is running while ownership of the outgoing memory goes back to the host. The bench starts transmit with the ownership bit at 0. It then checks that no byte leaves and that the busy flag holds. After that it sets ownership and checks that the same frame comes out complete, ending on byte 2047. The receive path is driven across the end of the memory, and the wrapped bytes are read back at addresses 2046, 2047, 0 and 1. Receive-enabled traffic offered while the host owns the incoming memory is checked at the ports: the count, the status and the stored bytes all stay as they were.

// File: rtl/pb_pkg.sv
// pb_pkg: register offsets and bit positions shared by the dual packet
// buffer and its checker. Assumes a 5-bit host offset bus.
package pb_pkg;
    localparam logic [4:0] OFS_PTR_LO = 5'h10;
    localparam logic [4:0] OFS_PTR_HI = 5'h11;
    localparam logic [4:0] OFS_MODE   = 5'h12;
    localparam logic [4:0] OFS_STAT   = 5'h13;
    localparam logic [4:0] OFS_RXDATA = 5'h14;
    localparam logic [4:0] OFS_TXDATA = 5'h15;

    localparam int MB_MUX = 0;
    localparam int MB_XMT = 5;
    localparam int MB_RCV = 6;
    localparam int MB_DMA = 7;

    localparam int SB_DMA = 3;
    localparam int SB_XMT = 4;
    localparam int SB_RCV = 5;

    localparam int BUF_TX = 0;
    localparam int BUF_RX = 1;
endpackage

// File: rtl/pb_bytemem.sv
// pb_bytemem: byte-wide memory with one write port and one asynchronous
// read port. Assumes only one side addresses it in a given cycle; the
// owner mux in the parent steers both ports. Contents are not reset.
module pb_bytemem #(
    parameter int DEPTH = 2048,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [7:0]       wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [7:0]       rdata
);
    logic [7:0] mem [DEPTH];

    // Store one byte per enabled cycle.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/pb_tx_engine.sv
// pb_tx_engine: walks the outgoing memory from a start index to the last
// byte. Presents a byte only while active and while the memory faces the
// network. Assumes DEPTH is a power of two.
module pb_tx_engine #(
    parameter int DEPTH = 2048,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [IDX_W-1:0] start_idx,
    input  logic             active,
    input  logic             net_side,
    input  logic             ready,
    output logic [IDX_W-1:0] rd_idx,
    output logic             valid,
    output logic             last,
    output logic             done
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    logic [IDX_W-1:0] idx_q;

    // Load the first byte on start, step on each accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n)                 idx_q <= '0;
        else if (start)             idx_q <= start_idx;
        else if (valid && ready)    idx_q <= idx_q + 1'b1;
    end

    assign rd_idx = idx_q;
    assign valid  = active && net_side;
    assign last   = valid && (idx_q == LAST_IDX);
    assign done   = last && ready;
endmodule

// File: rtl/pb_rx_engine.sv
// pb_rx_engine: stores offered bytes at consecutive, wrapping addresses
// and counts them. Accepts only while active and while the memory faces
// the network. Assumes DEPTH is a power of two.
module pb_rx_engine #(
    parameter int DEPTH = 2048,
    parameter int IDX_W = $clog2(DEPTH),
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [IDX_W-1:0] start_idx,
    input  logic             active,
    input  logic             net_side,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       wr_data,
    output logic [CNT_W-1:0] count,
    output logic             done
);
    logic [IDX_W-1:0] idx_q;
    logic [CNT_W-1:0] cnt_q;
    logic             take;

    assign take = active && net_side && in_valid;

    // Write position: loaded on start, advanced per stored byte.
    always_ff @(posedge clk) begin
        if (!rst_n)     idx_q <= '0;
        else if (start) idx_q <= start_idx;
        else if (take)  idx_q <= idx_q + 1'b1;
    end

    // Frame length: cleared on start, counts stored bytes.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (start) cnt_q <= '0;
        else if (take)  cnt_q <= cnt_q + 1'b1;
    end

    assign wr_en   = take;
    assign wr_idx  = idx_q;
    assign wr_data = in_data;
    assign count   = cnt_q;
    assign done    = take && in_last;
endmodule

// File: rtl/pktbuf_window.sv
// pktbuf_window: two packet memories behind a host register window with
// an auto-stepping pointer. Mode bit 0 hands one memory to the host and
// the other to the network engines. Start bits clear themselves when
// their activity completes. Assumes one host access per strobe cycle and
// a power-of-two buffer size.
module pktbuf_window
    import pb_pkg::*;
#(
    parameter int BUF_BYTES = 2048,
    parameter int PTR_W     = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [4:0] host_addr,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    output logic       net_tx_valid,
    input  logic       net_tx_ready,
    output logic [7:0] net_tx_data,
    output logic       net_tx_last,
    input  logic       net_rx_valid,
    input  logic [7:0] net_rx_data,
    input  logic       net_rx_last,
    input  logic       dma_done
);
    localparam int IDX_W  = $clog2(BUF_BYTES);
    localparam int NBUF   = 2;

    logic [PTR_W-1:0] ptr_q;
    logic             mux_q, tx_en_q, rx_en_q, dma_en_q;
    logic             mode_wr, tx_start, rx_start;
    logic             tx_done, rx_done;
    logic [NBUF-1:0]  own_host, port_hit;
    logic             data_acc;
    logic [IDX_W-1:0] host_idx, tx_idx, rx_idx;
    logic             rx_we;
    logic [7:0]       rx_wd;
    logic [PTR_W-1:0] rx_count;
    logic [IDX_W-1:0] net_idx [NBUF];
    logic             net_we  [NBUF];
    logic [7:0]       net_wd  [NBUF];
    logic [7:0]       rd_data [NBUF];
    logic [7:0]       host_mem_rd;

    assign host_idx = ptr_q[IDX_W-1:0];
    assign mode_wr  = host_wr && (host_addr == OFS_MODE);
    assign tx_start = mode_wr && host_wdata[MB_XMT] && !tx_en_q;
    assign rx_start = mode_wr && host_wdata[MB_RCV] && !rx_en_q;

    // Which memory faces the host, and which data port hits it.
    always_comb begin
        own_host[BUF_TX] = !mux_q;
        own_host[BUF_RX] = mux_q;
        port_hit[BUF_TX] = (host_addr == OFS_TXDATA) && !mux_q;
        port_hit[BUF_RX] = (host_addr == OFS_RXDATA) && mux_q;
    end

    assign data_acc = (host_wr || host_rd) && (|port_hit);

    // Pointer: byte loads from the host, one step per data-port access.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (host_wr && host_addr == OFS_PTR_LO)
            ptr_q[7:0] <= host_wdata;
        else if (host_wr && host_addr == OFS_PTR_HI)
            ptr_q[PTR_W-1:8] <= host_wdata[PTR_W-9:0];
        else if (data_acc)
            ptr_q <= ptr_q + 1'b1;
    end

    // Mode bits: loaded by host writes, activity bits cleared on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mux_q    <= 1'b0;
            tx_en_q  <= 1'b0;
            rx_en_q  <= 1'b0;
            dma_en_q <= 1'b0;
        end else if (mode_wr) begin
            mux_q    <= host_wdata[MB_MUX];
            tx_en_q  <= host_wdata[MB_XMT] && (tx_start || !tx_done);
            rx_en_q  <= host_wdata[MB_RCV] && (rx_start || !rx_done);
            dma_en_q <= host_wdata[MB_DMA] && (!dma_en_q || !dma_done);
        end else begin
            tx_en_q  <= tx_en_q  && !tx_done;
            rx_en_q  <= rx_en_q  && !rx_done;
            dma_en_q <= dma_en_q && !dma_done;
        end
    end

    pb_tx_engine #(.DEPTH(BUF_BYTES), .IDX_W(IDX_W)) i_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (tx_start),
        .start_idx (host_idx),
        .active    (tx_en_q),
        .net_side  (mux_q),
        .ready     (net_tx_ready),
        .rd_idx    (tx_idx),
        .valid     (net_tx_valid),
        .last      (net_tx_last),
        .done      (tx_done)
    );

    pb_rx_engine #(.DEPTH(BUF_BYTES), .IDX_W(IDX_W), .CNT_W(PTR_W)) i_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (rx_start),
        .start_idx (host_idx),
        .active    (rx_en_q),
        .net_side  (!mux_q),
        .in_valid  (net_rx_valid),
        .in_data   (net_rx_data),
        .in_last   (net_rx_last),
        .wr_en     (rx_we),
        .wr_idx    (rx_idx),
        .wr_data   (rx_wd),
        .count     (rx_count),
        .done      (rx_done)
    );

    // Network-side port of each memory.
    always_comb begin
        net_idx[BUF_TX] = tx_idx;
        net_we[BUF_TX]  = 1'b0;
        net_wd[BUF_TX]  = 8'h00;
        net_idx[BUF_RX] = rx_idx;
        net_we[BUF_RX]  = rx_we;
        net_wd[BUF_RX]  = rx_wd;
    end

    // One memory per direction, each steered by its owner.
    for (genvar g = 0; g < NBUF; g++) begin : g_buf
        pb_bytemem #(.DEPTH(BUF_BYTES), .IDX_W(IDX_W)) i_mem (
            .clk   (clk),
            .we    (own_host[g] ? (host_wr && port_hit[g]) : net_we[g]),
            .waddr (own_host[g] ? host_idx : net_idx[g]),
            .wdata (own_host[g] ? host_wdata : net_wd[g]),
            .raddr (own_host[g] ? host_idx : net_idx[g]),
            .rdata (rd_data[g])
        );
    end

    assign host_mem_rd = mux_q ? rd_data[BUF_RX] : rd_data[BUF_TX];
    assign net_tx_data = rd_data[BUF_TX];

    // Host read multiplexer.
    always_comb begin
        host_rdata = 8'h00;
        unique case (host_addr)
            OFS_PTR_LO: host_rdata = rx_count[7:0];
            OFS_PTR_HI: host_rdata = rx_count[PTR_W-1:8];
            OFS_STAT: begin
                host_rdata[SB_RCV] = rx_en_q;
                host_rdata[SB_XMT] = tx_en_q;
                host_rdata[SB_DMA] = dma_en_q;
            end
            OFS_RXDATA: host_rdata = port_hit[BUF_RX] ? host_mem_rd : 8'h00;
            OFS_TXDATA: host_rdata = port_hit[BUF_TX] ? host_mem_rd : 8'h00;
            default:    host_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/pktbuf_window_chk.sv
// pktbuf_window_chk: temporal properties of the packet buffer window,
// bound to the top module. Assumes the default 16-bit pointer.
module pktbuf_window_chk
    import pb_pkg::*;
#(
    parameter int PTR_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [4:0]       host_addr,
    input logic             host_wr,
    input logic             host_rd,
    input logic [7:0]       host_rdata,
    input logic             net_tx_valid,
    input logic             net_tx_ready,
    input logic             net_tx_last,
    input logic             dma_done,
    input logic             mux,
    input logic             tx_busy,
    input logic             rx_busy,
    input logic             dma_busy,
    input logic [PTR_W-1:0] ptr,
    input logic [PTR_W-1:0] rx_count
);
    logic mode_wr, any_acc, owned_acc, foreign_acc;

    assign mode_wr     = host_wr && host_addr == OFS_MODE;
    assign any_acc     = host_wr || host_rd;
    assign owned_acc   = any_acc && ((host_addr == OFS_RXDATA && mux) ||
                                     (host_addr == OFS_TXDATA && !mux));
    assign foreign_acc = any_acc && ((host_addr == OFS_RXDATA && !mux) ||
                                     (host_addr == OFS_TXDATA && mux));

    // R3: a data-port access steps the pointer by one
    p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        owned_acc |=> ptr == $past(ptr) + 1'b1);

    // R4: an access to the port of the network-owned memory leaves the pointer
    p_ptr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        foreign_acc |=> $stable(ptr));

    // R6: transmit bytes appear only while running and facing the network
    p_tx_side_r6: assert property (@(posedge clk) disable iff (!rst_n)
        net_tx_valid |-> (mux && tx_busy));

    // R5: the accepted last byte ends the transmit
    p_tx_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (net_tx_valid && net_tx_last && net_tx_ready && !mode_wr) |=> !tx_busy);

    // R7: with receive idle the count does not move
    p_rx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_busy && !mode_wr) |=> $stable(rx_count));

    // R9: the completion pulse ends the DMA flag
    p_dma_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_busy && dma_done && !mode_wr) |=> !dma_busy);

    // R10: reserved status bits read zero
    p_stat_resv_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == OFS_STAT) |->
            (host_rdata[7:6] == 2'b00 && host_rdata[2:0] == 3'b000));

    // R2: offset 0x10 reads back the received count
    p_count_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == OFS_PTR_LO) |-> host_rdata == rx_count[7:0]);
endmodule

bind pktbuf_window pktbuf_window_chk #(.PTR_W(PTR_W)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_addr    (host_addr),
    .host_wr      (host_wr),
    .host_rd      (host_rd),
    .host_rdata   (host_rdata),
    .net_tx_valid (net_tx_valid),
    .net_tx_ready (net_tx_ready),
    .net_tx_last  (net_tx_last),
    .dma_done     (dma_done),
    .mux          (mux_q),
    .tx_busy      (tx_en_q),
    .rx_busy      (rx_en_q),
    .dma_busy     (dma_en_q),
    .ptr          (ptr_q),
    .rx_count     (rx_count)
);

// File: tb/test_pktbuf_window.sv
`timescale 1ns/1ps
// test_pktbuf_window: table of host accesses, then directed tests for
// transmit, pause, receive with wrap, ownership, DMA flag and reset.
module test_pktbuf_window;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] host_addr = '0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       net_tx_valid, net_tx_last;
    logic       net_tx_ready = 1'b1;
    logic [7:0] net_tx_data;
    logic       net_rx_valid = 1'b0, net_rx_last = 1'b0;
    logic [7:0] net_rx_data = '0;
    logic       dma_done = 1'b0;

    int errors = 0, checks = 0;
    bit finished = 1'b0;
    logic [7:0] got_b [16];
    bit         got_l [16];
    int         ngot = 0;
    logic [7:0] rv;

    always #2.5 clk = ~clk;

    pktbuf_window i_pktbuf_window (.*);

    // Collect every accepted transmit byte.
    always @(posedge clk) begin
        if (net_tx_valid && net_tx_ready && ngot < 16) begin
            got_b[ngot] = net_tx_data;
            got_l[ngot] = net_tx_last;
            ngot = ngot + 1;
        end
    end

    // op: 0 write, 1 read and compare
    localparam int NV = 20;
    localparam logic [39:0] VEC [NV] = '{
        {8'd0, 8'h10, 8'h05, 8'h00, 8'd2},  // R2 pointer low
        {8'd0, 8'h11, 8'h00, 8'h00, 8'd2},  // R2 pointer high
        {8'd0, 8'h15, 8'hA1, 8'h00, 8'd3},
        {8'd0, 8'h15, 8'hB2, 8'h00, 8'd3},
        {8'd0, 8'h10, 8'h05, 8'h00, 8'd3},
        {8'd1, 8'h15, 8'h00, 8'hA1, 8'd3},  // R3 read at pointer
        {8'd1, 8'h15, 8'h00, 8'hB2, 8'd3},  // R3 pointer stepped
        {8'd0, 8'h10, 8'h05, 8'h00, 8'd3},
        {8'd0, 8'h11, 8'h08, 8'h00, 8'd3},
        {8'd1, 8'h15, 8'h00, 8'hA1, 8'd3},  // R3 0x0805 wraps to 0x005
        {8'd1, 8'h14, 8'h00, 8'h00, 8'd4},  // R4 foreign port reads 0
        {8'd1, 8'h15, 8'h00, 8'hB2, 8'd4},  // R4 pointer not stepped
        {8'd1, 8'h10, 8'h00, 8'h00, 8'd2},  // R2 count reads 0
        {8'd1, 8'h13, 8'h00, 8'h00, 8'd10}, // R10 status idle
        {8'd0, 8'h12, 8'h01, 8'h00, 8'd4},
        {8'd0, 8'h10, 8'h05, 8'h00, 8'd4},
        {8'd0, 8'h11, 8'h00, 8'h00, 8'd4},
        {8'd0, 8'h15, 8'h5A, 8'h00, 8'd4},  // R4 write ignored
        {8'd0, 8'h12, 8'h00, 8'h00, 8'd4},
        {8'd1, 8'h15, 8'h00, 8'hA1, 8'd4}   // R4 byte kept, pointer held
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic hwr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hrd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic set_ptr(input logic [15:0] p);
        hwr(5'h10, p[7:0]);
        hwr(5'h11, p[15:8]);
    endtask

    task automatic rx_byte(input logic [7:0] d, input logic l);
        @(negedge clk);
        net_rx_valid = 1'b1; net_rx_data = d; net_rx_last = l;
        @(negedge clk);
        net_rx_valid = 1'b0; net_rx_last = 1'b0;
    endtask

    task automatic check_frame(input string req);
        check(req, 16'(ngot), 16'd4);
        check(req, {8'h00, got_b[0]}, 16'h0011);
        check(req, {8'h00, got_b[3]}, 16'h0044);
        check(req, {15'd0, got_l[3]}, 16'd1);
        check(req, {15'd0, got_l[2]}, 16'd0);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: state after reset
        hrd(5'h13, rv); check("R1 status", {8'h0, rv}, 16'h0000);
        hrd(5'h10, rv); check("R1 count", {8'h0, rv}, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][39:32] == 8'd0) hwr(VEC[i][28:24], VEC[i][23:16]);
            else begin
                hrd(VEC[i][28:24], rv);
                check($sformatf("R%0d vector %0d", VEC[i][7:0], i), {8'h0, rv}, {8'h0, VEC[i][15:8]});
            end
        end

        // R5: frame of four bytes ending at byte 2047
        set_ptr(16'h07FC);
        hwr(5'h15, 8'h11); hwr(5'h15, 8'h22); hwr(5'h15, 8'h33); hwr(5'h15, 8'h44);
        set_ptr(16'h07FC);
        ngot = 0;
        hwr(5'h12, 8'h21);
        hrd(5'h13, rv); check("R5 busy", {8'h0, rv}, 16'h0010);
        repeat (10) @(negedge clk);
        hrd(5'h13, rv); check("R5 done", {8'h0, rv}, 16'h0000);
        check_frame("R5 frame");

        // R6: start with memory on host side, then hand it over
        ngot = 0;
        hwr(5'h12, 8'h20);
        repeat (8) @(negedge clk);
        check("R6 no bytes", 16'(ngot), 16'd0);
        hrd(5'h13, rv); check("R6 held busy", {8'h0, rv}, 16'h0010);
        hwr(5'h12, 8'h21);
        repeat (10) @(negedge clk);
        hrd(5'h13, rv); check("R6 resumed done", {8'h0, rv}, 16'h0000);
        check_frame("R6 frame");

        // R7 and R11: receive across the end of the memory
        hwr(5'h12, 8'h00);
        set_ptr(16'h07FE);
        hwr(5'h12, 8'h40);
        hrd(5'h13, rv); check("R7 rx busy", {8'h0, rv}, 16'h0020);
        rx_byte(8'hC1, 1'b0); rx_byte(8'hC2, 1'b0);
        rx_byte(8'hC3, 1'b0); rx_byte(8'hC4, 1'b1);
        hrd(5'h13, rv); check("R7 rx done", {8'h0, rv}, 16'h0000);
        hrd(5'h10, rv); check("R7 count lo", {8'h0, rv}, 16'h0004);
        hrd(5'h11, rv); check("R7 count hi", {8'h0, rv}, 16'h0000);
        hwr(5'h12, 8'h01);
        set_ptr(16'h07FE);
        hrd(5'h14, rv); check("R7 byte 2046", {8'h0, rv}, 16'h00C1);
        hrd(5'h14, rv); check("R7 byte 2047", {8'h0, rv}, 16'h00C2);
        hrd(5'h14, rv); check("R11 wrap byte 0", {8'h0, rv}, 16'h00C3);
        hrd(5'h14, rv); check("R11 wrap byte 1", {8'h0, rv}, 16'h00C4);
        rx_byte(8'h99, 1'b1);
        hrd(5'h10, rv); check("R7 disabled ignored", {8'h0, rv}, 16'h0004);

        // R8: receive enabled while host owns the incoming memory
        set_ptr(16'h07FE);
        hwr(5'h12, 8'h41);
        rx_byte(8'hEE, 1'b1);
        hrd(5'h13, rv); check("R8 still busy", {8'h0, rv}, 16'h0020);
        hrd(5'h10, rv); check("R8 count held", {8'h0, rv}, 16'h0000);
        hrd(5'h14, rv); check("R8 byte kept", {8'h0, rv}, 16'h00C1);
        hrd(5'h15, rv); check("R4 foreign tx port", {8'h0, rv}, 16'h0000);
        hrd(5'h14, rv); check("R4 pointer held", {8'h0, rv}, 16'h00C2);
        hwr(5'h12, 8'h01);
        hrd(5'h13, rv); check("R10 abort receive", {8'h0, rv}, 16'h0000);

        // R9: DMA flag
        hwr(5'h12, 8'h80);
        hrd(5'h13, rv); check("R9 dma set", {8'h0, rv}, 16'h0008);
        @(negedge clk); dma_done = 1'b1;
        @(negedge clk); dma_done = 1'b0;
        hrd(5'h13, rv); check("R9 dma cleared", {8'h0, rv}, 16'h0000);

        // R1: reset in the middle of activity
        hwr(5'h12, 8'h00);
        set_ptr(16'h0000);
        hwr(5'h15, 8'h77);
        hwr(5'h12, 8'h40);
        rx_byte(8'h12, 1'b1);
        hrd(5'h10, rv); check("R7 one byte", {8'h0, rv}, 16'h0001);
        set_ptr(16'h0005);
        hwr(5'h12, 8'hA0);
        hrd(5'h13, rv); check("R10 status bits", {8'h0, rv}, 16'h0018);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        hrd(5'h13, rv); check("R1 status after reset", {8'h0, rv}, 16'h0000);
        hrd(5'h10, rv); check("R1 count after reset", {8'h0, rv}, 16'h0000);
        hrd(5'h15, rv); check("R1 pointer zero", {8'h0, rv}, 16'h0077);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule